// File: doc/BRIEF.md
# FIFO Almost-Empty / Almost-Full Flag Generator

This block produces the almost-empty and almost-full status flags of a FIFO from the FIFO's fill count. The FIFO memory and its pointers sit outside the block, and the current number of stored words arrives on an input. The block holds two programmable thresholds. The empty threshold sets how few words count as "almost empty". The full threshold sets how little free space counts as "almost full".

At master reset both thresholds take one of eight preset values, chosen by a three-bit select input that is sampled while the reset is held. After reset, software can overwrite the thresholds in two ways. Parallel loading puts whole words on a load bus. Serial loading feeds one bit per enabled clock. A partial reset clears the flag state and restarts both loading sequences, but the programmed thresholds survive it. A timing-mode input chooses how the flags behave. In registered mode each flag is a register on its own side's clock: almost-empty on the read clock and almost-full on the write clock. In combinational mode both flags follow the fill count directly.

Top module: `almost_flag_gen`

## Requirements
- R1: `almost_empty` is 1 exactly when `fill_cnt` is less than or equal to the empty threshold.
- R2: `almost_full` is 1 exactly when `DEPTH - fill_cnt` is less than or equal to the full threshold.
- R3: At a clock edge with `mrst_n` low, both thresholds load the preset chosen by `preset_sel` = k. The preset value is 2^(k+3) - 1, so k = 0 gives 7, k = 2 gives 31 and k = 7 gives 1023.
- R4: At each write-clock edge with `ld` and `wen` both 1, `load_word` is stored. The first such word after a reset goes to the empty threshold, the second to the full threshold, and the third goes back to the empty threshold.
- R5: At each write-clock edge with `ser_en` at 1, one bit of `ser_in` is stored. Bits 0 to 9 of the empty threshold are written first, LSB first, then bits 0 to 9 of the full threshold. After those 20 bits the sequence wraps back to the start.
- R6: When a parallel load and a serial bit arrive at the same edge, only the parallel load takes effect, and the serial position does not advance.
- R7: A partial reset (`prst_n` low while `mrst_n` is high) keeps both thresholds. It restarts the parallel and serial sequences at the empty threshold and sets the registered flags to `almost_empty` = 1 and `almost_full` = 0.
- R8: Master reset sets the registered flags to `almost_empty` = 1 and `almost_full` = 0, and restarts both loading sequences.
- R9: With `async_mode` = 1, the flags follow `fill_cnt` in the same cycle. With `async_mode` = 0, each flag shows the comparison taken at the last rising edge of its own clock.
- R10: `wen` without `ld`, or idle cycles with `ser_en` low, leave both thresholds unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-side clock; runs the threshold registers and the almost-full register |
| rd_clk | input | 1 | Read-side clock; runs the almost-empty register |
| mrst_n | input | 1 | Master reset, synchronous, active low |
| prst_n | input | 1 | Partial reset, synchronous, active low |
| preset_sel | input | 3 | Selects the preset threshold, sampled during master reset |
| async_mode | input | 1 | 1 = combinational flags, 0 = registered flags |
| ld | input | 1 | Parallel load qualifier |
| wen | input | 1 | Write enable; together with `ld`, stores `load_word` |
| load_word | input | OFS_W | Parallel threshold value |
| ser_en | input | 1 | Serial bit enable |
| ser_in | input | 1 | Serial threshold bit |
| fill_cnt | input | CNT_W | Number of words currently stored in the FIFO |
| almost_empty | output | 1 | Almost-empty flag |
| almost_full | output | 1 | Almost-full flag |

## Verification
The hardest situation to reach from the ports is a collision between a parallel word and a serial bit in the same cycle. Close to it is a partial reset that lands halfway through a loading sequence. Both leave their traces only in hidden sequence positions. The bench drives the collision directly and then shifts a full 20-bit serial stream. If the serial position had slipped, one bit would move into the full threshold, and that shows up at the almost-full boundary. For the partial reset, the bench leaves both sequences mid-way, pulses `prst_n`, and then reloads. The destination of each new word shows up on the flags at the exact threshold fill levels.

// File: rtl/afg_pkg.sv
// Package afg_pkg
// Shared constants and helpers for the almost-flag generator.
// Assumes presets form the series 2^(k+base)-1 for k in 0..7.
package afg_pkg;

    localparam int unsigned NUM_PRESETS  = 8;
    localparam int unsigned PRESET_SEL_W = $clog2(NUM_PRESETS);

    typedef enum logic {
        FLAG_REGISTERED    = 1'b0,
        FLAG_COMBINATIONAL = 1'b1
    } flag_timing_e;

    // Preset threshold in words for select value k.
    function automatic int unsigned preset_words(input int unsigned k,
                                                 input int unsigned base);
        return (32'd1 << (k + base)) - 32'd1;
    endfunction

endpackage

// File: rtl/afg_offset_bank.sv
// Module afg_offset_bank
// Holds the empty and full thresholds. Loads presets at master reset,
// parallel words (empty, then full, wrapping) and serial bits (LSB first,
// empty then full, wrapping). A parallel load wins over a serial bit.
// Assumes both resets are synchronous to clk and active low.
module afg_offset_bank #(
    parameter int unsigned OFS_W       = 10,
    parameter int unsigned PRESET_BASE = 3
) (
    input  logic                              clk,
    input  logic                              mrst_n,
    input  logic                              prst_n,
    input  logic [afg_pkg::PRESET_SEL_W-1:0]  preset_sel,
    input  logic                              ld,
    input  logic                              wen,
    input  logic [OFS_W-1:0]                  load_word,
    input  logic                              ser_en,
    input  logic                              ser_in,
    output logic [OFS_W-1:0]                  ofs_empty,
    output logic [OFS_W-1:0]                  ofs_full
);
    localparam int unsigned SER_LEN = 2 * OFS_W;
    localparam int unsigned SER_W   = $clog2(SER_LEN);

    logic [OFS_W-1:0] preset_tab [afg_pkg::NUM_PRESETS];
    logic [OFS_W-1:0] preset_val;
    logic [OFS_W-1:0] empty_ser_nxt;
    logic [OFS_W-1:0] full_ser_nxt;
    logic             word_sel;
    logic [SER_W-1:0] ser_pos;
    logic             par_hit;
    logic             ser_hit;

    // Preset table computed from the package series.
    for (genvar k = 0; k < afg_pkg::NUM_PRESETS; k++) begin : g_preset
        assign preset_tab[k] = OFS_W'(afg_pkg::preset_words(k, PRESET_BASE));
    end

    assign preset_val = preset_tab[preset_sel];
    assign par_hit    = ld & wen;
    assign ser_hit    = ser_en & ~par_hit;

    // Merge the incoming serial bit into whichever threshold owns ser_pos.
    always_comb begin
        for (int i = 0; i < OFS_W; i++) begin
            empty_ser_nxt[i] = (ser_pos == SER_W'(i))         ? ser_in : ofs_empty[i];
            full_ser_nxt[i]  = (ser_pos == SER_W'(i + OFS_W)) ? ser_in : ofs_full[i];
        end
    end

    // Threshold storage and load sequencing.
    always_ff @(posedge clk) begin
        if (!mrst_n) begin
            ofs_empty <= preset_val;
            ofs_full  <= preset_val;
            word_sel  <= 1'b0;
            ser_pos   <= '0;
        end else if (!prst_n) begin
            word_sel  <= 1'b0;
            ser_pos   <= '0;
        end else if (par_hit) begin
            if (!word_sel) ofs_empty <= load_word;
            else           ofs_full  <= load_word;
            word_sel <= ~word_sel;
        end else if (ser_hit) begin
            ofs_empty <= empty_ser_nxt;
            ofs_full  <= full_ser_nxt;
            ser_pos   <= (ser_pos == SER_W'(SER_LEN - 1)) ? '0 : ser_pos + 1'b1;
        end
    end

endmodule

// File: rtl/afg_flag_cell.sv
// Module afg_flag_cell
// One status flag: true when level <= threshold. Either drives the
// comparison straight out or a register of it, chosen by async_mode.
// Assumes rst_n is synchronous to clk; RST_VAL is the flag's reset state.
module afg_flag_cell #(
    parameter int unsigned LVL_W   = 11,
    parameter int unsigned OFS_W   = 10,
    parameter logic        RST_VAL = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             async_mode,
    input  logic [LVL_W-1:0] level,
    input  logic [OFS_W-1:0] offset,
    output logic             flag
);
    logic hit;
    logic flag_q;

    // Threshold compare, widened to the level width.
    assign hit = (level <= LVL_W'(offset));

    // Registered copy of the compare.
    always_ff @(posedge clk) begin
        if (!rst_n) flag_q <= RST_VAL;
        else        flag_q <= hit;
    end

    // Timing-mode selection.
    assign flag = (afg_pkg::flag_timing_e'(async_mode) == afg_pkg::FLAG_COMBINATIONAL)
                  ? hit : flag_q;

endmodule

// File: rtl/almost_flag_gen.sv
// Module almost_flag_gen
// Almost-empty / almost-full flag generator for a FIFO of DEPTH words.
// Thresholds live on the write clock. Almost-empty is registered on
// rd_clk and almost-full on wr_clk. fill_cnt must be valid in both domains.
module almost_flag_gen #(
    parameter int unsigned DEPTH       = 1024,
    parameter int unsigned OFS_W       = 10,
    parameter int unsigned PRESET_BASE = 3,
    localparam int unsigned CNT_W      = $clog2(DEPTH + 1)
) (
    input  logic                              wr_clk,
    input  logic                              rd_clk,
    input  logic                              mrst_n,
    input  logic                              prst_n,
    input  logic [afg_pkg::PRESET_SEL_W-1:0]  preset_sel,
    input  logic                              async_mode,
    input  logic                              ld,
    input  logic                              wen,
    input  logic [OFS_W-1:0]                  load_word,
    input  logic                              ser_en,
    input  logic                              ser_in,
    input  logic [CNT_W-1:0]                  fill_cnt,
    output logic                              almost_empty,
    output logic                              almost_full
);
    logic [OFS_W-1:0] ofs_empty_w;
    logic [OFS_W-1:0] ofs_full_w;
    logic [CNT_W-1:0] free_cnt;
    logic             flag_rst_n;

    // Either reset returns the flag registers to the empty-FIFO state.
    assign flag_rst_n = mrst_n & prst_n;
    assign free_cnt   = CNT_W'(DEPTH) - fill_cnt;

    afg_offset_bank #(
        .OFS_W       (OFS_W),
        .PRESET_BASE (PRESET_BASE)
    ) u_bank (
        .clk        (wr_clk),
        .mrst_n     (mrst_n),
        .prst_n     (prst_n),
        .preset_sel (preset_sel),
        .ld         (ld),
        .wen        (wen),
        .load_word  (load_word),
        .ser_en     (ser_en),
        .ser_in     (ser_in),
        .ofs_empty  (ofs_empty_w),
        .ofs_full   (ofs_full_w)
    );

    afg_flag_cell #(
        .LVL_W   (CNT_W),
        .OFS_W   (OFS_W),
        .RST_VAL (1'b1)
    ) u_ae (
        .clk        (rd_clk),
        .rst_n      (flag_rst_n),
        .async_mode (async_mode),
        .level      (fill_cnt),
        .offset     (ofs_empty_w),
        .flag       (almost_empty)
    );

    afg_flag_cell #(
        .LVL_W   (CNT_W),
        .OFS_W   (OFS_W),
        .RST_VAL (1'b0)
    ) u_af (
        .clk        (wr_clk),
        .rst_n      (flag_rst_n),
        .async_mode (async_mode),
        .level      (free_cnt),
        .offset     (ofs_full_w),
        .flag       (almost_full)
    );

endmodule

// File: rtl/afg_checker.sv
// Module afg_checker
// Temporal checks for almost_flag_gen, attached with bind.
module afg_checker #(
    parameter int unsigned DEPTH       = 1024,
    parameter int unsigned OFS_W       = 10,
    parameter int unsigned PRESET_BASE = 3,
    parameter int unsigned CNT_W       = 11
) (
    input logic                              wr_clk,
    input logic                              rd_clk,
    input logic                              mrst_n,
    input logic                              prst_n,
    input logic [afg_pkg::PRESET_SEL_W-1:0]  preset_sel,
    input logic                              async_mode,
    input logic                              ld,
    input logic                              wen,
    input logic [OFS_W-1:0]                  load_word,
    input logic                              ser_en,
    input logic [CNT_W-1:0]                  fill_cnt,
    input logic                              almost_empty,
    input logic                              almost_full,
    input logic [OFS_W-1:0]                  ofs_empty,
    input logic [OFS_W-1:0]                  ofs_full
);
    assert_ae_at_zero_R1: assert property (@(posedge rd_clk) disable iff (!mrst_n)
        (async_mode && fill_cnt == '0) |-> almost_empty);

    assert_af_at_depth_R2: assert property (@(posedge wr_clk) disable iff (!mrst_n)
        (async_mode && fill_cnt == CNT_W'(DEPTH)) |-> almost_full);

    assert_preset_load_R3: assert property (@(posedge wr_clk) disable iff (!prst_n)
        !mrst_n |=> (ofs_empty == OFS_W'(afg_pkg::preset_words(int'($past(preset_sel)), PRESET_BASE))
                  && ofs_full  == OFS_W'(afg_pkg::preset_words(int'($past(preset_sel)), PRESET_BASE))));

    assert_par_lands_R4: assert property (@(posedge wr_clk) disable iff (!mrst_n || !prst_n)
        (ld && wen) |=> (ofs_empty == $past(load_word) || ofs_full == $past(load_word)));

    assert_keep_on_partial_R7: assert property (@(posedge wr_clk) disable iff (!mrst_n)
        !prst_n |=> ($stable(ofs_empty) && $stable(ofs_full)));

    assert_partial_af_clear_R7: assert property (@(posedge wr_clk) disable iff (!mrst_n)
        (!prst_n && !async_mode) |=> (async_mode || !almost_full));

    assert_partial_ae_set_R7: assert property (@(posedge rd_clk) disable iff (!mrst_n)
        (!prst_n && !async_mode) |=> (async_mode || almost_empty));

    assert_reg_ae_follows_R9: assert property (@(posedge rd_clk) disable iff (!mrst_n || !prst_n)
        (!async_mode && fill_cnt == '0) |=> (async_mode || almost_empty));

    assert_idle_holds_R10: assert property (@(posedge wr_clk) disable iff (!mrst_n)
        (!(ld && wen) && !ser_en) |=> ($stable(ofs_empty) && $stable(ofs_full)));

endmodule

bind almost_flag_gen afg_checker #(
    .DEPTH       (DEPTH),
    .OFS_W       (OFS_W),
    .PRESET_BASE (PRESET_BASE),
    .CNT_W       (CNT_W)
) u_afg_checker (
    .wr_clk       (wr_clk),
    .rd_clk       (rd_clk),
    .mrst_n       (mrst_n),
    .prst_n       (prst_n),
    .preset_sel   (preset_sel),
    .async_mode   (async_mode),
    .ld           (ld),
    .wen          (wen),
    .load_word    (load_word),
    .ser_en       (ser_en),
    .fill_cnt     (fill_cnt),
    .almost_empty (almost_empty),
    .almost_full  (almost_full),
    .ofs_empty    (ofs_empty_w),
    .ofs_full     (ofs_full_w)
);

// File: tb/almost_flag_gen_bench.sv
module almost_flag_gen_bench;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 1024;
    localparam int OFS_W      = 10;
    localparam int CNT_W      = 11;

    typedef struct packed {
        logic [CNT_W-1:0] fill;
        logic             amode;
        logic             ae;
        logic             af;
    } vec_t;

    // Both thresholds at 31 (preset select 2).
    localparam vec_t VEC [14] = '{
        '{11'd0,    1'b1, 1'b1, 1'b0},
        '{11'd31,   1'b1, 1'b1, 1'b0},
        '{11'd32,   1'b1, 1'b0, 1'b0},
        '{11'd500,  1'b1, 1'b0, 1'b0},
        '{11'd992,  1'b1, 1'b0, 1'b0},
        '{11'd993,  1'b1, 1'b0, 1'b1},
        '{11'd1024, 1'b1, 1'b0, 1'b1},
        '{11'd0,    1'b0, 1'b1, 1'b0},
        '{11'd31,   1'b0, 1'b1, 1'b0},
        '{11'd32,   1'b0, 1'b0, 1'b0},
        '{11'd500,  1'b0, 1'b0, 1'b0},
        '{11'd992,  1'b0, 1'b0, 1'b0},
        '{11'd993,  1'b0, 1'b0, 1'b1},
        '{11'd1024, 1'b0, 1'b0, 1'b1}
    };

    logic             clk = 1'b0;
    logic             mrst_n = 1'b0;
    logic             prst_n = 1'b1;
    logic [2:0]       preset_sel = 3'd0;
    logic             async_mode = 1'b0;
    logic             ld = 1'b0;
    logic             wen = 1'b0;
    logic [OFS_W-1:0] load_word = '0;
    logic             ser_en = 1'b0;
    logic             ser_in = 1'b0;
    logic [CNT_W-1:0] fill_cnt = '0;
    logic             almost_empty;
    logic             almost_full;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    almost_flag_gen u_almost_flag_gen (
        .wr_clk       (clk),
        .rd_clk       (clk),
        .mrst_n       (mrst_n),
        .prst_n       (prst_n),
        .preset_sel   (preset_sel),
        .async_mode   (async_mode),
        .ld           (ld),
        .wen          (wen),
        .load_word    (load_word),
        .ser_en       (ser_en),
        .ser_in       (ser_in),
        .fill_cnt     (fill_cnt),
        .almost_empty (almost_empty),
        .almost_full  (almost_full)
    );

    task automatic check(input string req, input logic ae_exp, input logic af_exp);
        n_tests++;
        if (almost_empty !== ae_exp || almost_full !== af_exp) begin
            n_fail++;
            $display("FAIL %s: ae=%b af=%b expected ae=%b af=%b fill=%0d",
                     req, almost_empty, almost_full, ae_exp, af_exp, fill_cnt);
        end
    endtask

    // Drive fill and mode at negedge, then sample just after the next posedge.
    task automatic apply_fill(input int f, input logic m);
        @(negedge clk);
        fill_cnt   = CNT_W'(f);
        async_mode = m;
        @(posedge clk);
        #1;
    endtask

    task automatic master_reset(input logic [2:0] s);
        @(negedge clk);
        mrst_n     = 1'b0;
        preset_sel = s;
        @(negedge clk);
        mrst_n = 1'b1;
    endtask

    task automatic par_word(input int v);
        @(negedge clk);
        ld = 1'b1; wen = 1'b1; load_word = OFS_W'(v);
        @(negedge clk);
        ld = 1'b0; wen = 1'b0;
    endtask

    task automatic ser_bits(input int v, input int nbits);
        for (int i = 0; i < nbits; i++) begin
            @(negedge clk);
            ser_en = 1'b1;
            ser_in = v[i];
        end
        @(negedge clk);
        ser_en = 1'b0;
    endtask

    task automatic ser_pair(input int e, input int f);
        ser_bits(e | (f << OFS_W), 2 * OFS_W);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL R9 watchdog: run not finished, expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        // R8: reset state of the registered flags while master reset is held
        fill_cnt = CNT_W'(600);
        preset_sel = 3'd2;
        @(posedge clk); #1;
        check("R8 flags during master reset", 1'b1, 1'b0);
        @(negedge clk);
        mrst_n = 1'b1;
        @(posedge clk); #1;
        check("R8 flags after master reset release", 1'b0, 1'b0);

        // R1 R2 R9: vector table, thresholds 31/31 from preset 2 (R3)
        foreach (VEC[i]) begin
            apply_fill(int'(VEC[i].fill), VEC[i].amode);
            check($sformatf("R1/R2 vector %0d", i), VEC[i].ae, VEC[i].af);
        end

        // R9: registered flag lags until the next edge; combinational does not
        apply_fill(0, 1'b0);
        @(negedge clk);
        fill_cnt = CNT_W'(500);
        #1;
        check("R9 registered flag holds before edge", 1'b1, 1'b0);
        @(posedge clk); #1;
        check("R9 registered flag after edge", 1'b0, 1'b0);
        @(negedge clk);
        async_mode = 1'b1;
        fill_cnt   = CNT_W'(10);
        #1;
        check("R9 combinational flag same cycle", 1'b1, 1'b0);

        // R3: smallest preset (7)
        master_reset(3'd0);
        apply_fill(7, 1'b1);    check("R3 preset0 ae boundary", 1'b1, 1'b0);
        apply_fill(8, 1'b1);    check("R3 preset0 ae above", 1'b0, 1'b0);
        apply_fill(1017, 1'b1); check("R3 preset0 af boundary", 1'b0, 1'b1);
        apply_fill(1016, 1'b1); check("R3 preset0 af below", 1'b0, 1'b0);

        // R3: largest preset (1023)
        master_reset(3'd7);
        apply_fill(1023, 1'b1); check("R3 preset7 ae boundary", 1'b1, 1'b1);
        apply_fill(1024, 1'b1); check("R3 preset7 ae above", 1'b0, 1'b1);
        apply_fill(1, 1'b1);    check("R3 preset7 af boundary", 1'b1, 1'b1);
        apply_fill(0, 1'b1);    check("R3 preset7 af below", 1'b1, 1'b0);

        // R4: parallel load order, empty then full then wrap
        par_word(100);
        par_word(200);
        apply_fill(100, 1'b1); check("R4 first word to empty", 1'b1, 1'b0);
        apply_fill(101, 1'b1); check("R4 first word to empty above", 1'b0, 1'b0);
        apply_fill(824, 1'b1); check("R4 second word to full", 1'b0, 1'b1);
        apply_fill(823, 1'b1); check("R4 second word to full below", 1'b0, 1'b0);
        par_word(50);
        apply_fill(50, 1'b1);  check("R4 third word wraps to empty", 1'b1, 1'b0);
        apply_fill(51, 1'b1);  check("R4 third word wraps above", 1'b0, 1'b0);
        apply_fill(824, 1'b1); check("R4 full kept after wrap", 1'b0, 1'b1);

        // R6: simultaneous parallel and serial request
        master_reset(3'd0);
        @(negedge clk);
        ld = 1'b1; wen = 1'b1; load_word = OFS_W'(3); ser_en = 1'b1; ser_in = 1'b0;
        @(negedge clk);
        ld = 1'b0; wen = 1'b0; ser_en = 1'b0;
        apply_fill(3, 1'b1); check("R6 parallel wins", 1'b1, 1'b0);
        apply_fill(4, 1'b1); check("R6 parallel wins above", 1'b0, 1'b0);

        // R5: serial stream empty=20 full=7, position unchanged by R6 cycle
        ser_pair(20, 7);
        apply_fill(20, 1'b1);   check("R5 serial empty boundary", 1'b1, 1'b0);
        apply_fill(21, 1'b1);   check("R5 serial empty above", 1'b0, 1'b0);
        apply_fill(1017, 1'b1); check("R5 serial full boundary", 1'b0, 1'b1);
        apply_fill(1016, 1'b1); check("R5 serial full below", 1'b0, 1'b0);

        // R10: wen without ld has no effect
        @(negedge clk);
        wen = 1'b1; load_word = OFS_W'(500);
        @(negedge clk);
        wen = 1'b0;
        apply_fill(21, 1'b1);  check("R10 empty unchanged", 1'b0, 1'b0);
        apply_fill(600, 1'b1); check("R10 full unchanged", 1'b0, 1'b0);

        // R7: partial reset mid-sequence (3 serial zeros -> empty 16)
        ser_bits(0, 3);
        preset_sel = 3'd7;
        apply_fill(1020, 1'b0); check("R7 before partial reset", 1'b0, 1'b1);
        @(negedge clk);
        prst_n = 1'b0;
        @(posedge clk); #1;
        check("R7 flags during partial reset", 1'b1, 1'b0);
        @(negedge clk);
        prst_n = 1'b1;
        @(posedge clk); #1;
        check("R7 flags after partial reset", 1'b0, 1'b1);
        apply_fill(16, 1'b1); check("R7 empty threshold kept", 1'b1, 1'b0);
        apply_fill(17, 1'b1); check("R7 empty threshold kept above", 1'b0, 1'b0);
        ser_pair(33, 9);
        apply_fill(33, 1'b1);   check("R7 serial restarted empty", 1'b1, 1'b0);
        apply_fill(34, 1'b1);   check("R7 serial restarted empty above", 1'b0, 1'b0);
        apply_fill(1015, 1'b1); check("R7 serial restarted full", 1'b0, 1'b1);
        apply_fill(1014, 1'b1); check("R7 serial restarted full below", 1'b0, 1'b0);
        @(negedge clk);
        prst_n = 1'b0;
        @(negedge clk);
        prst_n = 1'b1;
        par_word(60);
        apply_fill(60, 1'b1);  check("R7 parallel restarted at empty", 1'b1, 1'b0);
        apply_fill(964, 1'b1); check("R7 full not overwritten", 1'b0, 1'b0);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule